// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block sits behind the analog stages of a multi-stage pipelined converter and turns their raw decisions into one corrected output word per clock. Each clock it takes a 4-bit code from the leading coarse stage, a 2-bit code from each of eight 1.5-bit stages, and a 3-bit code from the closing flash stage. The stages work on successive samples at the same time, so the code of one sample from each later stage arrives one clock after the code from the stage before it.

The block skews the early codes through per-stage delay lines so that all ten codes of one sample meet in the same cycle. It then adds them with weights that overlap by one bit at every stage boundary. A decision error of one code in any stage before the flash shows up as an opposite residue in later stages, so the sum cancels it. The sum has a fixed mid-scale offset removed and its two lowest bits dropped. It is then clamped at zero, limited at full scale, and registered together with a valid flag.

A sticky flag reports 1.5-bit codes that use the value no comparator pair can produce. Reset clears every delay line, so no valid word comes out until fresh samples have crossed the whole pipeline.

Top module: `adc_correct`

## Requirements
- R1: `out_valid` equals the `in_valid` applied 10 rising edges earlier, which is the alignment depth of 9 plus one output register.
- R2: 1.5-bit stage k (k = 1..8) appears on `mid_codes[2k-1:2k-2]` k cycles after its sample's `first_code`. The flash code appears 9 cycles after it. `out_sample` = (first·1024 + Σ code_k·2^(10−k) + flash − 1024) >> 2, with the dropped bits truncated.
- R3: If any stage before the flash is off by one code and later stages make up for it in their residue, the output equals the value the error-free codes give.
- R4: A 1.5-bit code of 3 (binary 11) is weighted as 2.
- R5: `code_err` rises at the edge after a 1.5-bit code of 3 is presented for a sample whose `in_valid` was 1. It then stays high until reset. Codes presented in slots of samples with `in_valid` = 0 never set it.
- R6: The output never wraps. A full-scale set of codes (first 15, all stages 2, flash 6 or 7) gives 4095.
- R7: A code set whose weighted sum lies below the 1024 offset gives 0.
- R8: While `rst_n` is low, `out_valid`, `out_sample` and `code_err` are 0. After release, samples that were in flight before reset never come out, and a new sample comes out 10 edges after it enters.
- R9: A new sample is accepted on every clock with no gaps, and each one comes out correctly.
- R10: While `out_valid` is 0, `out_sample` keeps the last valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| in_valid | input | 1 | Marks a real sample, aligned with `first_code` |
| first_code | input | 4 | Coarse leading-stage code |
| mid_codes | input | 16 | Eight 2-bit 1.5-bit-stage codes, stage 1 in bits 1:0 |
| flash_code | input | 3 | Closing flash-stage code |
| out_valid | output | 1 | Corrected word is valid |
| out_sample | output | 12 | Corrected, limited output word |
| code_err | output | 1 | Sticky flag for an illegal 1.5-bit code |

## Verification
The bound checker checks on every clock that the valid flag follows the input valid by exactly ten edges. It also checks that nothing valid comes out in the ten edges after reset, that the output word does not move while the valid flag is low, and that the error flag sets after an illegal code in any stage's valid slot and never clears by itself. Whether the overlapped sum is numerically right can only be shown by the bench's scenarios. These feed codes from an ideal residue model with injected one-code decision errors, and hand-worked words at zero, at full scale and around the offset. The bench scenarios also cover illegal codes weighted as 2, illegal codes in invalid slots that are ignored, and samples in flight across a reset that are discarded.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // 1.5-bit stage digit encodings
  localparam logic [1:0] DIG_LO  = 2'b00;
  localparam logic [1:0] DIG_MID = 2'b01;
  localparam logic [1:0] DIG_HI  = 2'b10;
  localparam logic [1:0] DIG_BAD = 2'b11;

  // An impossible digit is weighted as the top legal digit.
  function automatic logic [1:0] fold_digit(input logic [1:0] code);
    return (code == DIG_BAD) ? DIG_HI : code;
  endfunction

  function automatic logic is_bad_digit(input logic [1:0] code);
    return (code == DIG_BAD);
  endfunction

endpackage

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q   [DEPTH];
  logic [W-1:0] stg_nxt [DEPTH];

  always_comb begin
    stg_nxt[0] = d;
    for (int i = 1; i < DEPTH; i++) begin
      stg_nxt[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        stg_q[i] <= stg_nxt[i];
      end
    end
  end

  assign q = stg_q[DEPTH-1];

endmodule

// File: rtl/corr_align.sv
module corr_align #(
  parameter int FIRST_BITS = 4,
  parameter int NUM_MID    = 8,
  localparam int MID_W     = 2 * NUM_MID
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [FIRST_BITS-1:0] first_code,
  input  logic [MID_W-1:0]      mid_codes,
  output logic [FIRST_BITS-1:0] first_al,
  output logic [MID_W-1:0]      mid_al,
  output logic [NUM_MID:0]      vld_tap
);

  // vld_q[k] is in_valid delayed k+1 edges: the valid of the sample whose
  // stage-(k+1) code is on the inputs now; vld_q[NUM_MID] is the aligned valid.
  logic [NUM_MID:0] vld_q;
  logic [NUM_MID:0] vld_nxt;

  always_comb begin
    vld_nxt = {vld_q[NUM_MID-1:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_nxt;
    end
  end

  assign vld_tap = vld_q;

  // Leading stage waits for every later stage and the flash.
  corr_delay #(
    .W     (FIRST_BITS),
    .DEPTH (NUM_MID + 1)
  ) u_first_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (first_code),
    .q     (first_al)
  );

  // Stage k (0-based) arrives k+1 cycles late, so it waits NUM_MID-k cycles.
  for (genvar k = 0; k < NUM_MID; k++) begin : g_mid_dly
    corr_delay #(
      .W     (2),
      .DEPTH (NUM_MID - k)
    ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mid_codes[2*k +: 2]),
      .q     (mid_al[2*k +: 2])
    );
  end

endmodule

// File: rtl/corr_merge.sv
module corr_merge
  import adc_corr_pkg::*;
#(
  parameter int FIRST_BITS = 4,
  parameter int NUM_MID    = 8,
  parameter int FLASH_BITS = 3,
  parameter int OUT_BITS   = 12,
  localparam int MID_W     = 2 * NUM_MID
) (
  input  logic [FIRST_BITS-1:0] first_al,
  input  logic [MID_W-1:0]      mid_al,
  input  logic [FLASH_BITS-1:0] flash_al,
  output logic [OUT_BITS-1:0]   sample
);

  // Weight position of the leading stage's LSB.
  localparam int FIRST_SHIFT = FLASH_BITS - 1 + NUM_MID;
  // Raw sum width: leading stage plus at most twice its LSB weight.
  localparam int RAW_W  = FIRST_SHIFT + FIRST_BITS + 1;
  // Number of fine bits dropped after the offset is removed.
  localparam int DROP   = FIRST_SHIFT + FIRST_BITS - OUT_BITS;
  localparam int SPAN   = OUT_BITS + DROP;
  // Mid-scale offset: sum of all 1.5-bit weights plus half the flash range.
  localparam int OFFSET = 1 << FIRST_SHIFT;

  logic [1:0]            dig [NUM_MID];
  logic [RAW_W-1:0]      raw;
  logic signed [RAW_W:0] diff;
  logic [RAW_W-1:0]      mag;
  logic [OUT_BITS-1:0]   kept;

  for (genvar k = 0; k < NUM_MID; k++) begin : g_fold
    assign dig[k] = fold_digit(mid_al[2*k +: 2]);
  end

  // Overlapped shifted addition.
  always_comb begin
    raw = RAW_W'(flash_al);
    raw = raw + (RAW_W'(first_al) << FIRST_SHIFT);
    for (int k = 0; k < NUM_MID; k++) begin
      raw = raw + (RAW_W'(dig[k]) << (FIRST_SHIFT - 1 - k));
    end
  end

  always_comb begin
    diff = $signed({1'b0, raw}) - $signed((RAW_W + 1)'(OFFSET));
    mag  = diff[RAW_W-1:0];
  end

  if (DROP > 0) begin : g_trunc
    logic lsb_unused;
    assign lsb_unused = ^mag[DROP-1:0];
    assign kept       = mag[SPAN-1:DROP];
  end else begin : g_full
    assign kept = mag[SPAN-1:0];
  end

  // Clamp below zero, limit above full scale.
  always_comb begin
    if (diff[RAW_W]) begin
      sample = '0;
    end else if (mag[SPAN]) begin
      sample = '1;
    end else begin
      sample = kept;
    end
  end

endmodule

// File: rtl/adc_correct.sv
module adc_correct
  import adc_corr_pkg::*;
#(
  parameter int FIRST_BITS = 4,
  parameter int NUM_MID    = 8,
  parameter int FLASH_BITS = 3,
  parameter int OUT_BITS   = 12,
  localparam int MID_W     = 2 * NUM_MID
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [FIRST_BITS-1:0] first_code,
  input  logic [MID_W-1:0]      mid_codes,
  input  logic [FLASH_BITS-1:0] flash_code,
  output logic                  out_valid,
  output logic [OUT_BITS-1:0]   out_sample,
  output logic                  code_err
);

  logic [FIRST_BITS-1:0] first_al;
  logic [MID_W-1:0]      mid_al;
  logic [NUM_MID:0]      vld_tap;
  logic [OUT_BITS-1:0]   merged;
  logic [NUM_MID-1:0]    bad_hit;

  logic                  vld_nxt;
  logic                  data_en;
  logic [OUT_BITS-1:0]   sample_nxt;
  logic                  err_nxt;

  corr_align #(
    .FIRST_BITS (FIRST_BITS),
    .NUM_MID    (NUM_MID)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .first_code (first_code),
    .mid_codes  (mid_codes),
    .first_al   (first_al),
    .mid_al     (mid_al),
    .vld_tap    (vld_tap)
  );

  // The flash code is the last to arrive and needs no delay.
  corr_merge #(
    .FIRST_BITS (FIRST_BITS),
    .NUM_MID    (NUM_MID),
    .FLASH_BITS (FLASH_BITS),
    .OUT_BITS   (OUT_BITS)
  ) u_merge (
    .first_al   (first_al),
    .mid_al     (mid_al),
    .flash_al   (flash_code),
    .sample     (merged)
  );

  // Illegal digit seen on a stage input in a valid sample's slot.
  for (genvar k = 0; k < NUM_MID; k++) begin : g_bad
    assign bad_hit[k] = is_bad_digit(mid_codes[2*k +: 2]) & vld_tap[k];
  end

  always_comb begin
    vld_nxt    = vld_tap[NUM_MID];
    data_en    = vld_tap[NUM_MID];
    sample_nxt = merged;
    err_nxt    = code_err | (|bad_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      out_valid <= vld_nxt;
      code_err  <= err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
    end else if (data_en) begin
      out_sample <= sample_nxt;
    end
  end

endmodule

// File: rtl/adc_correct_chk.sv
module adc_correct_chk #(
  parameter int NUM_MID  = 8,
  parameter int OUT_BITS = 12,
  localparam int MID_W   = 2 * NUM_MID,
  localparam int LAT     = NUM_MID + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [MID_W-1:0]    mid_codes,
  input logic                out_valid,
  input logic [OUT_BITS-1:0] out_sample,
  input logic                code_err
);

  // Shadow history of in_valid: vh[i] is in_valid i+1 edges ago.
  logic [LAT-1:0] vh;
  logic [7:0]     cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vh  <= '0;
      cyc <= '0;
    end else begin
      vh  <= {vh[LAT-2:0], in_valid};
      if (cyc < 8'(LAT)) begin
        cyc <= cyc + 8'd1;
      end
    end
  end

  // R1: output valid follows input valid by the fixed latency
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vh[LAT-1]);

  // R8: nothing valid emerges before the pipeline refills
  p_refill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < 8'(LAT)) |-> !out_valid);

  // R5: error flag never clears on its own
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  // R5: illegal digit in a valid slot of any stage raises the flag
  for (genvar k = 0; k < NUM_MID; k++) begin : g_bad_chk
    p_bad_sets_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mid_codes[2*k +: 2] == 2'b11) && vh[k]) |=> code_err);
  end

  // R10: output word holds while not valid
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

endmodule

bind adc_correct adc_correct_chk #(
  .NUM_MID  (NUM_MID),
  .OUT_BITS (OUT_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mid_codes  (mid_codes),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .code_err   (code_err)
);

// File: tb/tb_adc_correct.sv
module tb_adc_correct;

  localparam int NUM_MID = 8;
  localparam int LAT     = 10;
  localparam int MAXS    = 512;

  typedef struct packed {
    logic [3:0]  f;
    logic [15:0] m;
    logic [2:0]  fl;
    logic        v;
    logic [11:0] e;
    logic [3:0]  tag;
  } vec_t;

  // first, stage codes (stage1 in bits 1:0), flash, valid, expected, requirement
  localparam vec_t TBL [13] = '{
    '{4'd0,  16'h0000, 3'd0, 1'b1, 12'd0,    4'd7 },  // R7 all zero
    '{4'd0,  16'h5555, 3'd4, 1'b1, 12'd0,    4'd2 },  // R2 exactly at offset
    '{4'd15, 16'hAAAA, 3'd7, 1'b1, 12'd4095, 4'd6 },  // R6 full scale
    '{4'd8,  16'h5555, 3'd4, 1'b1, 12'd2048, 4'd2 },  // R2 mid scale
    '{4'd15, 16'hFFFF, 3'd7, 1'b0, 12'd0,    4'd10},  // R10 / R5 invalid slot
    '{4'd8,  16'h5554, 3'd4, 1'b1, 12'd1920, 4'd3 },  // R3 coarse high, stage low
    '{4'd7,  16'h5556, 3'd4, 1'b1, 12'd1920, 4'd3 },  // R3 coarse low, stage high
    '{4'd1,  16'h5555, 3'd5, 1'b1, 12'd256,  4'd2 },  // R2 truncation
    '{4'd0,  16'h0000, 3'd7, 1'b1, 12'd0,    4'd7 },  // R7 below offset
    '{4'd3,  16'h2222, 3'd3, 1'b1, 12'd852,  4'd2 },  // R2 alternating stages
    '{4'd0,  16'h0000, 3'd0, 1'b0, 12'd0,    4'd10},  // R10 gap
    '{4'd15, 16'hAAAA, 3'd6, 1'b1, 12'd4095, 4'd6 },  // R6 near full scale
    '{4'd0,  16'h5555, 3'd3, 1'b1, 12'd0,    4'd7 }   // R7 one below offset
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  first_code;
  logic [15:0] mid_codes;
  logic [2:0]  flash_code;
  logic        out_valid;
  logic [11:0] out_sample;
  logic        code_err;

  adc_correct dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .first_code (first_code),
    .mid_codes  (mid_codes),
    .flash_code (flash_code),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .code_err   (code_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          nchk;
  int          nfail;
  logic [11:0] last_exp;
  logic        have_last;

  logic [3:0]  s_first [MAXS];
  logic [15:0] s_mid   [MAXS];
  logic [2:0]  s_flash [MAXS];
  logic        s_vld   [MAXS];
  logic [11:0] s_exp   [MAXS];
  int          s_tag   [MAXS];

  task automatic check(input bit ok, input int req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Ideal residue model producing stage codes for a 12-bit value x.
  function automatic void model(input int x, input bit inj,
                                output logic [3:0] f, output logic [15:0] m,
                                output logic [2:0] fl);
    int v;
    int c0;
    int r;
    v  = 4 * x;
    c0 = (v + 512) / 1024;
    if (c0 > 15) c0 = 15;
    r  = v - c0 * 1024;
    if (inj && ($urandom % 2 == 0)) begin
      if (r < 0 && c0 > 0) begin
        c0 = c0 - 1;
        r  = r + 1024;
      end else if (r >= 0 && c0 < 15) begin
        c0 = c0 + 1;
        r  = r - 1024;
      end
    end
    f = 4'(c0);
    m = '0;
    for (int k = 0; k < NUM_MID; k++) begin
      int w;
      int t;
      int tt;
      w = 512 >> k;
      if (r < -(w / 2))     t = -1;
      else if (r < (w / 2)) t = 0;
      else                  t = 1;
      if (inj && ($urandom % 3 == 0)) begin
        tt = t + (($urandom % 2 == 0) ? 1 : -1);
        if (tt >= -1 && tt <= 1 && (r - tt * w) >= -w && (r - tt * w) < w) t = tt;
      end
      r = r - t * w;
      m[2*k +: 2] = 2'(t + 1);
    end
    fl = 3'(r + 4);
  endfunction

  // Presents n samples with per-stage skew; checks outputs at each negedge.
  task automatic run_stream(input int n);
    for (int c = 0; c <= n + LAT; c++) begin
      int j;
      j = c - LAT;
      if (j >= 0 && j < n) begin
        check(out_valid == s_vld[j], 1, int'(out_valid), int'(s_vld[j]));  // R1
        if (s_vld[j]) begin
          check(out_sample == s_exp[j], s_tag[j], int'(out_sample), int'(s_exp[j]));
          last_exp  = s_exp[j];
          have_last = 1'b1;
        end else if (have_last) begin
          check(out_sample == last_exp, 10, int'(out_sample), int'(last_exp));  // R10
        end
      end else begin
        check(out_valid == 1'b0, 1, int'(out_valid), 0);  // R1 idle
      end
      in_valid   = (c < n) ? s_vld[c] : 1'b0;
      first_code = (c < n) ? s_first[c] : 4'd0;
      for (int k = 0; k < NUM_MID; k++) begin
        int jk;
        jk = c - (k + 1);
        mid_codes[2*k +: 2] = (jk >= 0 && jk < n) ? s_mid[jk][2*k +: 2] : 2'b00;
      end
      begin
        int jf;
        jf = c - (NUM_MID + 1);
        flash_code = (jf >= 0 && jf < n) ? s_flash[jf] : 3'd0;
      end
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    nchk       = 0;
    nfail      = 0;
    have_last  = 1'b0;
    last_exp   = '0;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    first_code = '0;
    mid_codes  = '0;
    flash_code = '0;
    repeat (3) @(negedge clk);

    // R8 reset state
    check(out_valid == 1'b0, 8, int'(out_valid), 0);
    check(out_sample == 12'd0, 8, int'(out_sample), 0);
    check(code_err == 1'b0, 8, int'(code_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed table: R2 R3 R6 R7 R10, invalid slot with code 3 for R5
    for (int i = 0; i < 13; i++) begin
      s_first[i] = TBL[i].f;
      s_mid[i]   = TBL[i].m;
      s_flash[i] = TBL[i].fl;
      s_vld[i]   = TBL[i].v;
      s_exp[i]   = TBL[i].e;
      s_tag[i]   = int'(TBL[i].tag);
    end
    run_stream(13);
    check(code_err == 1'b0, 5, int'(code_err), 0);  // R5 invalid slot ignored

    // Back-to-back model samples, half with decision errors: R9 R2 R3
    for (int i = 0; i < 300; i++) begin
      int  x;
      bit  inj;
      x   = (i == 0) ? 0 : (i == 1) ? 4095 : int'($urandom_range(4095));
      inj = (i % 2 == 1);
      model(x, inj, s_first[i], s_mid[i], s_flash[i]);
      s_vld[i] = 1'b1;
      s_exp[i] = 12'(x);
      s_tag[i] = inj ? 3 : 9;
    end
    run_stream(300);
    check(code_err == 1'b0, 5, int'(code_err), 0);  // R5 no illegal codes yet

    // R4: all stages illegal, weighted as 2 -> 1279; R5 flag sets
    s_first[0] = 4'd4;
    s_mid[0]   = 16'hFFFF;
    s_flash[0] = 3'd4;
    s_vld[0]   = 1'b1;
    s_exp[0]   = 12'd1279;
    s_tag[0]   = 4;
    run_stream(1);
    check(code_err == 1'b1, 5, int'(code_err), 1);
    repeat (5) @(negedge clk);
    check(code_err == 1'b1, 5, int'(code_err), 1);  // R5 sticky

    // R8: samples in flight are dropped by reset
    in_valid   = 1'b1;
    first_code = 4'd5;
    mid_codes  = 16'h5555;
    flash_code = 3'd4;
    repeat (4) @(negedge clk);
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    first_code = '0;
    mid_codes  = '0;
    flash_code = '0;
    @(negedge clk);
    check(out_valid == 1'b0, 8, int'(out_valid), 0);
    check(out_sample == 12'd0, 8, int'(out_sample), 0);
    check(code_err == 1'b0, 8, int'(code_err), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, 8, int'(out_valid), 0);
    end
    last_exp  = 12'd0;
    have_last = 1'b1;
    s_first[0] = 4'd8;
    s_mid[0]   = 16'h5555;
    s_flash[0] = 3'd4;
    s_vld[0]   = 1'b1;
    s_exp[0]   = 12'd2048;
    s_tag[0]   = 8;
    run_stream(1);  // R8 refill
    check(code_err == 1'b0, 8, int'(code_err), 0);

    summary();
    $finish;
  end

endmodule